// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Slave Address Filter

This block is the receive half of an asynchronous serial port of the classic 8-bit controller kind. It watches one serial input line at sixteen samples per bit time, paced by a sample tick from outside. It assembles either a ten-bit frame (start, eight data bits, stop) or an eleven-bit frame (start, eight data bits, a ninth bit, stop). The received byte and its extra bit go into holding registers, and a receive-complete flag is raised.

For bus networks with one master and many slaves, the block can gate the receive-complete flag with a hardware comparison of the received byte. The byte is compared against a masked own-address and against a broadcast address formed from the same two registers. Slaves that are not addressed then see no flag at all. A sticky framing-error flag records any frame whose stop bit was sampled low. This flag shares control bit 7 with the upper mode bit, and an option bit selects which of the two storage bits a read or write of bit 7 reaches.

Software reaches the block through a simple register port: a single-cycle write strobe with address and data, and a combinational read selected by a read address.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, registers 0 to 4 all read 0x00 and `ri_o` is 0. With a zero mask, every byte counts as an address match.
- R2: Register 0 (control) is laid out as bit 7 = upper mode bit or framing error, bit 6 = lower mode bit, bit 5 = address-filter enable, bit 2 = received extra bit (read only), bit 0 = receive-complete flag; bits 4, 3 and 1 read 0. The mode value {bit7 mode bit, bit6} is decoded as follows: 00 turns the receiver off, 01 selects a ten-bit frame, and 10 or 11 select an eleven-bit frame.
- R3: A falling edge seen on a tick starts a frame. Each bit is valued by a two-of-three vote of samples 7, 8 and 9, counted in ticks from that edge. Data arrive least significant bit first, and the byte is readable at register 4.
- R4: If the start bit's vote is 1, the edge is dropped as noise and the receiver waits for a new falling edge.
- R5: A stop bit that votes 0 sets the framing-error flag. The flag stays set through later error-free frames and is cleared only by a software write.
- R6: Register 1 bit 0 is the select bit. When it is 1, register-0 bit 7 reads and writes the framing-error flag. When it is 0, bit 7 reads and writes the upper mode bit. Each storage bit is untouched while the other one is selected.
- R7: With the address filter off, every complete frame sets the receive-complete flag. The register-0 bit 2 gets the ninth bit in eleven-bit frames and the stop bit in ten-bit frames.
- R8: With the filter on in an eleven-bit mode, the flag is set only when the ninth bit is 1 and the byte matches.
- R9: With the filter on in the ten-bit mode, the flag is set only when the stop bit is valid and the byte matches.
- R10: A byte matches if it equals register 2 in every bit where register 3 is 1. It also matches if it has a 1 in every bit where (register 2 OR register 3) is 1.
- R11: While the receive-complete flag is 1, a finished frame is discarded: register 4 and bit 2 keep their values. The framing-error rule of R5 still applies.
- R12: When a frame completes in the same cycle as a software write to register 0, the hardware setting of the receive-complete flag and the framing-error flag takes precedence over the written value.
- R13: Sampling advances only on cycles where `sample_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | Sample strobe at sixteen times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ri_o | output | 1 | Receive-complete flag |

## Verification
Completing a frame and a software write to the control register can fall in the same clock cycle. The collision is provoked by running the sample tick on every cycle, so the frame end lands exactly on the tick that carries the stop bit's ninth sample. The bench then issues a write to register 0 in that same cycle, clearing the receive-complete and framing-error flags. It is judged as follows: a flag that hardware sets in that cycle must read 1 afterwards. When the receive-complete flag was already 1, the frame must be discarded and the software clear must take effect.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_LONGA = 2'b10,
    MODE_LONGB = 2'b11
  } rx_mode_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_OPT  = 3'd1;
  localparam logic [2:0] REG_ADDR = 3'd2;
  localparam logic [2:0] REG_MASK = 3'd3;
  localparam logic [2:0] REG_BUF  = 3'd4;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b1;
        else        pipe_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b1;
        else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rx,
  input  logic          long_frame,
  output logic          done,
  output logic          stop_bit,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          busy
);

  localparam int CW         = $clog2(OVS);
  localparam int MID        = OVS / 2;
  localparam int IW         = $clog2(DW + 3);
  localparam int LAST_SHORT = DW + 1;
  localparam int LAST_LONG  = DW + 2;

  rx_state_e       state_q, state_n;
  logic [CW-1:0]   scnt_q, scnt_n;
  logic [IW-1:0]   bidx_q, bidx_n;
  logic [1:0]      vote_q, vote_n;
  logic [DW-1:0]   data_q, data_n;
  logic            ninth_q, ninth_n;
  logic            bit_val;
  logic            at_decide;
  logic [IW-1:0]   last_idx;

  assign bit_val   = vote3(vote_q[0], vote_q[1], rx);
  assign last_idx  = long_frame ? IW'(LAST_LONG) : IW'(LAST_SHORT);
  assign at_decide = en && tick && (state_q == RX_BUSY) && (scnt_q == CW'(MID + 1));

  always_comb begin
    state_n = state_q;
    scnt_n  = scnt_q;
    bidx_n  = bidx_q;
    vote_n  = vote_q;
    data_n  = data_q;
    ninth_n = ninth_q;
    if (!en) begin
      state_n = RX_IDLE;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (tick && !rx) begin
            state_n = RX_BUSY;
            scnt_n  = CW'(1);
            bidx_n  = '0;
          end
        end
        default: begin
          if (tick) begin
            scnt_n = scnt_q + CW'(1);
            if (scnt_q == CW'(MID - 1)) vote_n[0] = rx;
            if (scnt_q == CW'(MID))     vote_n[1] = rx;
          end
          if (at_decide) begin
            if (bidx_q == '0) begin
              if (bit_val) state_n = RX_IDLE;
              else         bidx_n  = IW'(1);
            end else if (bidx_q == last_idx) begin
              state_n = RX_IDLE;
            end else if (bidx_q <= IW'(DW)) begin
              data_n = {bit_val, data_q[DW-1:1]};
              bidx_n = bidx_q + IW'(1);
            end else begin
              ninth_n = bit_val;
              bidx_n  = bidx_q + IW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      scnt_q  <= '0;
      bidx_q  <= '0;
      vote_q  <= '0;
      data_q  <= '0;
      ninth_q <= 1'b0;
    end else begin
      state_q <= state_n;
      scnt_q  <= scnt_n;
      bidx_q  <= bidx_n;
      vote_q  <= vote_n;
      data_q  <= data_n;
      ninth_q <= ninth_n;
    end
  end

  assign done     = at_decide && (bidx_q == last_idx);
  assign stop_bit = bit_val;
  assign data     = data_q;
  assign ninth    = ninth_q;
  assign busy     = (state_q == RX_BUSY);

endmodule

// File: rtl/mpu_rx_addr_match.sv
module mpu_rx_addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] own_mask,
  output logic          hit_given,
  output logic          hit_bcast
);

  logic [DW-1:0] bcast_bits;

  assign bcast_bits = own_addr | own_mask;
  assign hit_given  = ~|((rx_byte ^ own_addr) & own_mask);
  assign hit_bcast  = ~|(bcast_bits & ~rx_byte);

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ri_o
);

  localparam int DW = 8;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          sm0_q, sm1_q, sm2_q, fe_q, ri_q, rb8_q, sel_q;
  logic          sm0_n, sm1_n, sm2_n, fe_n, ri_n, rb8_n, sel_n;
  logic [DW-1:0] saddr_q, saden_q, rbuf_q;
  logic [DW-1:0] saddr_n, saden_n, rbuf_n;

  logic          rx_s;
  logic          done, stop_bit, ninth, busy;
  logic [DW-1:0] rx_byte;
  logic          hit_given, hit_bcast, hit;
  rx_mode_e      mode;
  logic          rx_en, long_frame, short_frame;
  logic          accept, load, fe_set, wr_ctrl;

  assign mode        = rx_mode_e'({sm0_q, sm1_q});
  assign rx_en       = (mode != MODE_OFF);
  assign long_frame  = sm0_q;
  assign short_frame = (mode == MODE_SHORT);

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (rxd),
    .dout  (rx_s)
  );

  mpu_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (rx_en),
    .tick       (sample_tick),
    .rx         (rx_s),
    .long_frame (long_frame),
    .done       (done),
    .stop_bit   (stop_bit),
    .data       (rx_byte),
    .ninth      (ninth),
    .busy       (busy)
  );

  mpu_rx_addr_match #(.DW(DW)) u_match (
    .rx_byte   (rx_byte),
    .own_addr  (saddr_q),
    .own_mask  (saden_q),
    .hit_given (hit_given),
    .hit_bcast (hit_bcast)
  );

  assign hit     = hit_given | hit_bcast;
  assign accept  = !sm2_q || (short_frame ? (stop_bit && hit) : (ninth && hit));
  assign load    = done && !ri_q && accept;
  assign fe_set  = done && !stop_bit;
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

  always_comb begin
    sm0_n   = sm0_q;
    sm1_n   = sm1_q;
    sm2_n   = sm2_q;
    fe_n    = fe_q;
    ri_n    = ri_q;
    rb8_n   = rb8_q;
    sel_n   = sel_q;
    saddr_n = saddr_q;
    saden_n = saden_q;
    rbuf_n  = rbuf_q;
    if (wr_ctrl) begin
      if (sel_q) fe_n  = wr_data[7];
      else       sm0_n = wr_data[7];
      sm1_n = wr_data[6];
      sm2_n = wr_data[5];
      ri_n  = wr_data[0];
    end
    if (wr_en && (wr_addr == REG_OPT))  sel_n   = wr_data[0];
    if (wr_en && (wr_addr == REG_ADDR)) saddr_n = wr_data;
    if (wr_en && (wr_addr == REG_MASK)) saden_n = wr_data;
    if (fe_set) fe_n = 1'b1;
    if (load) begin
      ri_n   = 1'b1;
      rbuf_n = rx_byte;
      rb8_n  = short_frame ? stop_bit : ninth;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sm0_q   <= 1'b0;
      sm1_q   <= 1'b0;
      sm2_q   <= 1'b0;
      fe_q    <= 1'b0;
      ri_q    <= 1'b0;
      rb8_q   <= 1'b0;
      sel_q   <= 1'b0;
      saddr_q <= '0;
      saden_q <= '0;
      rbuf_q  <= '0;
    end else begin
      sm0_q   <= sm0_n;
      sm1_q   <= sm1_n;
      sm2_q   <= sm2_n;
      fe_q    <= fe_n;
      ri_q    <= ri_n;
      rb8_q   <= rb8_n;
      sel_q   <= sel_n;
      saddr_q <= saddr_n;
      saden_q <= saden_n;
      rbuf_q  <= rbuf_n;
    end
  end

  always_comb begin
    case (rd_addr)
      REG_CTRL: rd_data = {(sel_q ? fe_q : sm0_q), sm1_q, sm2_q, 2'b00, rb8_q, 1'b0, ri_q};
      REG_OPT:  rd_data = {7'd0, sel_q};
      REG_ADDR: rd_data = saddr_q;
      REG_MASK: rd_data = saden_q;
      REG_BUF:  rd_data = rbuf_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign ri_o = ri_q;

endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       fe_q,
  input logic       sel_q,
  input logic       ri_q,
  input logic [7:0] rbuf_q,
  input logic       done,
  input logic       stop_bit,
  input logic       ninth,
  input logic       hit,
  input logic       sm0_q,
  input logic       sm1_q,
  input logic       sm2_q,
  input logic       busy
);

  // R5
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(fe_q) |-> $past(wr_en && (wr_addr == 3'd0) && sel_q && !wr_data[7]));

  // R11
  held_buffer_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !$stable(rbuf_q) |-> $past(done && !ri_q));

  // R7
  open_accept_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !ri_q && !sm2_q) |=> ri_q);

  // R8
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && sm2_q && sm0_q && !(ninth && hit) && !(wr_en && (wr_addr == 3'd0)))
      |=> $stable(ri_q));

  // R2
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ({sm0_q, sm1_q} == 2'b00) |=> !busy);

  // R12
  fe_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !stop_bit) |=> fe_q);

endmodule

bind mp_uart_rx mp_uart_rx_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .fe_q     (fe_q),
  .sel_q    (sel_q),
  .ri_q     (ri_q),
  .rbuf_q   (rbuf_q),
  .done     (done),
  .stop_bit (stop_bit),
  .ninth    (ninth),
  .hit      (hit),
  .sm0_q    (sm0_q),
  .sm1_q    (sm1_q),
  .sm2_q    (sm2_q),
  .busy     (busy)
);

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick;
  logic       rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       ri_o;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_every = 1;
  int cyc_ct = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc_ct <= cyc_ct + 1;
    sample_tick <= (tick_every == 1) || ((cyc_ct % tick_every) == 0);
  end

  mp_uart_rx i_mp_uart_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .rxd         (rxd),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .ri_o        (ri_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Control value with select bit 0: {mode[1], mode[0], filter, 0000, ri}
  function automatic logic [7:0] ctl(input logic [1:0] mode, input logic f, input logic ri);
    return {mode, f, 4'b0000, ri};
  endfunction

  function automatic logic exp_hit(input logic [7:0] b, input logic [7:0] a, input logic [7:0] m);
    logic given, bc;
    given = (((b ^ a) & m) == 8'h00);
    bc    = (((a | m) & ~b) == 8'h00);
    return given | bc;
  endfunction

  function automatic logic exp_accept(input logic short_f, input logic f, input logic n9,
                                      input logic stp, input logic h);
    if (!f) return 1'b1;
    return short_f ? (stp & h) : (n9 & h);
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic n9, input logic stp,
                            input logic long_f, input int coll_at, input logic [7:0] coll_d);
    logic [10:0] v;
    int nb;
    int bl;
    nb = long_f ? 11 : 10;
    bl = 16 * tick_every;
    v = '1;
    v[0] = 1'b0;
    v[8:1] = b;
    if (long_f) begin v[9] = n9; v[10] = stp; end
    else        v[9] = stp;
    for (int c = 0; c < nb * bl; c++) begin
      @(negedge clk);
      rxd = v[c / bl];
      if (c == coll_at) begin
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = coll_d;
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    rxd = 1'b1; wr_en = 1'b0;
    repeat (48) @(negedge clk);
  endtask

  // Sets the configuration and clears the receive and error flags.
  task automatic setup(input logic [1:0] mode, input logic f, input logic [7:0] a, input logic [7:0] m);
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd0, ctl(mode, f, 1'b0));
    reg_wr(3'd2, a);
    reg_wr(3'd3, m);
    reg_wr(3'd1, 8'h01);
    reg_wr(3'd0, {1'b0, mode[0], f, 5'b0});
    reg_wr(3'd1, 8'h00);
  endtask

  task automatic read_fe(output logic fe);
    logic [7:0] d;
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd0, d);
    fe = d[7];
    reg_wr(3'd1, 8'h00);
  endtask

  // One filtered or unfiltered frame, judged against the bench model.
  task automatic run_case(input string tag, input logic [1:0] mode, input logic f,
                          input logic [7:0] a, input logic [7:0] m, input logic [7:0] b,
                          input logic n9, input logic stp);
    logic [7:0] old_buf, ctl_old, d, ctl_now;
    logic acc, fe;
    setup(mode, f, a, m);
    reg_rd(3'd4, old_buf);
    reg_rd(3'd0, ctl_old);
    send_frame(b, n9, stp, mode != 2'b01, -1, 8'h00);
    acc = exp_accept(mode == 2'b01, f, n9, stp, exp_hit(b, a, m));
    reg_rd(3'd0, ctl_now);
    check({tag, " ri"}, ctl_now[0], acc);
    reg_rd(3'd4, d);
    check({tag, " buf"}, d, acc ? b : old_buf);
    check({tag, " bit2"}, ctl_now[2], acc ? ((mode == 2'b01) ? stp : n9) : ctl_old[2]);
    read_fe(fe);
    check({tag, " fe"}, fe, !stp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic fe;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset values
    for (int r = 0; r < 5; r++) begin
      reg_rd(r[2:0], d);
      check("R1 reset reg", d, 8'h00);
    end
    check("R1 ri_o", ri_o, 1'b0);

    // R2 mode off: a frame is ignored
    send_frame(8'hA5, 1'b0, 1'b1, 1'b0, -1, 8'h00);
    reg_rd(3'd0, d);
    check("R2 off no ri", d[0], 1'b0);
    reg_rd(3'd4, d);
    check("R2 off buf", d, 8'h00);

    // R3 / R7 ten-bit frame, filter off
    run_case("R3 R7 short", 2'b01, 1'b0, 8'h00, 8'h00, 8'hC3, 1'b0, 1'b1);
    run_case("R7 long n9=0", 2'b10, 1'b0, 8'h00, 8'h00, 8'h5E, 1'b0, 1'b1);
    run_case("R7 long n9=1", 2'b11, 1'b0, 8'h00, 8'h00, 8'h81, 1'b1, 1'b1);

    // R4 glitch shorter than the vote window
    setup(2'b01, 1'b0, 8'h00, 8'h00);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    reg_rd(3'd0, d);
    check("R4 glitch no ri", d[0], 1'b0);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0, -1, 8'h00);
    reg_rd(3'd4, d);
    check("R4 frame after glitch", d, 8'h3C);

    // R8 / R10 filtered eleven-bit: addr 55 mask F0
    run_case("R8 R10 given", 2'b10, 1'b1, 8'h55, 8'hF0, 8'h5A, 1'b1, 1'b1);
    run_case("R8 data byte", 2'b10, 1'b1, 8'h55, 8'hF0, 8'h5A, 1'b0, 1'b1);
    run_case("R10 bcast", 2'b11, 1'b1, 8'h55, 8'hF0, 8'hF5, 1'b1, 1'b1);
    run_case("R10 miss", 2'b11, 1'b1, 8'h55, 8'hF0, 8'h35, 1'b1, 1'b1);
    run_case("R1 R10 zero mask", 2'b10, 1'b1, 8'h00, 8'h00, 8'h6B, 1'b1, 1'b1);

    // R9 filtered ten-bit
    run_case("R9 good stop", 2'b01, 1'b1, 8'h55, 8'hF0, 8'h5A, 1'b0, 1'b1);
    run_case("R9 bad stop", 2'b01, 1'b1, 8'h55, 8'hF0, 8'h5A, 1'b0, 1'b0);

    // R5 sticky error
    setup(2'b01, 1'b0, 8'h00, 8'h00);
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, -1, 8'h00);
    reg_wr(3'd0, ctl(2'b01, 1'b0, 1'b0));
    send_frame(8'h12, 1'b0, 1'b1, 1'b0, -1, 8'h00);
    read_fe(fe);
    check("R5 fe sticky", fe, 1'b1);
    reg_wr(3'd1, 8'h01);
    reg_wr(3'd0, 8'h40);
    reg_rd(3'd0, d);
    check("R5 fe cleared", d[7], 1'b0);
    reg_wr(3'd1, 8'h00);

    // R6 shared bit 7
    reg_wr(3'd0, 8'hC0);
    reg_rd(3'd0, d);
    check("R6 sm0 view", d[7], 1'b1);
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd0, d);
    check("R6 fe view", d[7], 1'b0);
    reg_wr(3'd0, 8'h80 | 8'h40);
    reg_wr(3'd1, 8'h00);
    reg_rd(3'd0, d);
    check("R6 sm0 kept", d[7], 1'b1);
    reg_wr(3'd0, 8'h40);
    reg_rd(3'd0, d);
    check("R6 sm0 write", d[7], 1'b0);
    read_fe(fe);
    check("R6 fe kept", fe, 1'b1);

    // R11 flag already set: frame discarded
    setup(2'b01, 1'b0, 8'h00, 8'h00);
    send_frame(8'h21, 1'b0, 1'b1, 1'b0, -1, 8'h00);
    send_frame(8'h22, 1'b0, 1'b0, 1'b0, -1, 8'h00);
    reg_rd(3'd4, d);
    check("R11 buf held", d, 8'h21);
    reg_rd(3'd0, d);
    check("R11 bit2 held", d[2], 1'b1);
    read_fe(fe);
    check("R11 fe still set", fe, 1'b1);

    // R12 collisions at the completion cycle (tick every cycle, ten-bit frame)
    setup(2'b01, 1'b0, 8'h00, 8'h00);
    send_frame(8'h33, 1'b0, 1'b1, 1'b0, 155, ctl(2'b01, 1'b0, 1'b0));
    check("R12 ri set wins", ri_o, 1'b1);
    reg_rd(3'd4, d);
    check("R12 buf loaded", d, 8'h33);
    send_frame(8'h34, 1'b0, 1'b1, 1'b0, 155, ctl(2'b01, 1'b0, 1'b0));
    check("R12 R11 clear applied", ri_o, 1'b0);
    reg_rd(3'd4, d);
    check("R12 R11 buf kept", d, 8'h33);
    setup(2'b01, 1'b0, 8'h00, 8'h00);
    reg_wr(3'd1, 8'h01);
    send_frame(8'h44, 1'b0, 1'b0, 1'b0, 155, 8'h40);
    reg_rd(3'd0, d);
    check("R12 fe set wins", d[7], 1'b1);
    check("R12 ri with fe", d[0], 1'b1);
    reg_wr(3'd1, 8'h00);

    // R13 slower tick
    tick_every = 2;
    run_case("R13 half tick", 2'b10, 1'b0, 8'h00, 8'h00, 8'h96, 1'b1, 1'b1);
    tick_every = 1;

    // Random frames against the model
    for (int i = 0; i < 40; i++) begin
      logic [1:0] mode;
      logic [7:0] a, m, b;
      logic f;
      mode = 2'($urandom_range(1, 3));
      f = 1'($urandom);
      a = 8'($urandom);
      case ($urandom_range(0, 2))
        0: m = 8'h00;
        1: m = 8'hFF;
        default: m = 8'($urandom);
      endcase
      case ($urandom_range(0, 2))
        0: b = a;
        1: b = a | m;
        default: b = 8'($urandom);
      endcase
      run_case("R3 R7 R8 R9 R10 rand", mode, f, a, m, b, 1'($urandom), ($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule